// File: doc/BRIEF.md
# I2C Host Controller

This block is a single-master I2C controller that a processor drives through a small register bank. The host puts the target address and the direction into an address register. It then writes the control register to launch a start condition and the address byte. After that it moves data one byte at a time through a shared data port. Every bus event is reported as a sticky flag in a status register. The host re-arms a flag by writing zero to that bit, and the engine watches some of these flags to decide when to move the next byte.

The block does not divide the clock. A separate divider supplies a `tick` enable, and each tick advances the bit engine by one quarter of an SCL period. Both bus lines are open drain. The block only tells the pad whether to pull each line low, and it reads the resolved line levels back. A force-stop control bit closes the transfer: in a read, the last byte is answered with NACK and then a stop; in a write, a stop follows the byte already sent. A pin-override mode gives the host direct control of both lines, for example to recover a stuck bus.

Top module: `i2c_host_ctrl`

## Requirements
- R1: The control register (offset 0x04, bits 7:0), the interrupt-enable register (0x14, bits 6:0) and the address register (0x20, bits 7:0) read back what was written. Every register reads zero after reset, and both lines are released.
- R2: A write to the status register (0x0C, bits 6:0) clears each bit written as 0 and keeps each bit written as 1. Writing zero clears all of it.
- R3: When idle, a control write with bit3 (enable) and bit0 (start) set and bit4 clear produces a start condition, which is SDA falling while SCL is high. It then shifts out address-register bits 7:0 MSB first, where bit 0 is 1 for a read. SDA never changes while SCL is high during a byte.
- R4: At the end of the address byte, status bit0 is set, together with bit1 (data ready) for a read or bit3 (transmit empty) for a write.
- R5: A byte the controller sends that gets no acknowledge (SDA high on the ninth clock) sets status bit6.
- R6: In write mode, a write to the data port (0x24) sends bits 7:0 MSB first. When that byte completes, status bits 2 and 3 are set.
- R7: In read mode, clearing status bit1 receives a byte and acknowledges it (SDA low on the ninth clock). Status bit1 is then set and the data port returns the byte in bits 7:0.
- R8: If control bit1 (force stop) is set when a read byte begins, that byte is answered with NACK and followed by a stop. The stop sets status bit4.
- R9: If control bit1 is set while a write is waiting between bytes, a stop is issued and status bit4 is set.
- R10: If SDA is read low while the controller is releasing it during a byte it sends, status bit5 is set, both lines are released and the engine returns to idle.
- R11: With control bit4 set, SCL follows bit6 and SDA follows bit5 (1 releases the line, 0 pulls it low), and the engine stays idle.
- R12: `irq` is high exactly when some status bit and its enable bit are both set.
- R13: The engine does not pass the SCL-high part of a bit while SCL is held low by another device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Quarter-bit enable from the clock divider |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register byte offset |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume a few things about the environment. Reset is held across the first clock. Another device pulls SCL low only while SCL is already low. Pin override is not switched on and off in the middle of a byte. The host follows the flag handshake and does not write the data port while a write byte is in progress. The bench target model only stretches SCL after it has seen SCL low. Its SDA forcing for the arbitration case starts with the bus idle. Every register access is made between transfers or while the engine is waiting on a flag.

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_pull,
  output logic          sda_pull
);
  localparam logic [AW-1:0] A_CTRL = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(12);
  localparam logic [AW-1:0] A_IEN  = AW'(20);
  localparam logic [AW-1:0] A_TGT  = AW'(32);
  localparam logic [AW-1:0] A_DATA = AW'(36);

  typedef enum logic [2:0] {IDLE, START, XFER, HOLD, STOP} st_t;
  st_t state;

  logic [7:0] ctrl, tgt, rxb, sh;
  logic [6:0] stat, ien;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic rx, addr_ph, stop_after, ackbit, scl_low, sda_low;
  logic unused_hi;

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_stat = wr_en && addr == A_STAT;
  wire wr_ien  = wr_en && addr == A_IEN;
  wire wr_tgt  = wr_en && addr == A_TGT;
  wire wr_data = wr_en && addr == A_DATA;
  wire override = ctrl[4];
  wire launch = wr_ctrl && wdata[3] && wdata[0] && !wdata[4];

  assign unused_hi = ^wdata[DW-1:8];
  assign irq = |(stat & ien);
  assign scl_pull = override ? !ctrl[6] : scl_low;
  assign sda_pull = override ? !ctrl[5] : sda_low;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = DW'(ctrl);
      A_STAT:  rdata = DW'(stat);
      A_IEN:   rdata = DW'(ien);
      A_TGT:   rdata = DW'(tgt);
      A_DATA:  rdata = DW'(rxb);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE; ctrl <= '0; stat <= '0; ien <= '0; tgt <= '0; rxb <= '0;
      sh <= '0; ph <= '0; bitn <= '0; rx <= 1'b0; addr_ph <= 1'b0;
      stop_after <= 1'b0; ackbit <= 1'b0; scl_low <= 1'b0; sda_low <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= wdata[7:0];
      if (wr_ien)  ien  <= wdata[6:0];
      if (wr_tgt)  tgt  <= wdata[7:0];
      if (wr_stat) stat <= stat & wdata[6:0];
      if (override) begin
        state <= IDLE; scl_low <= 1'b0; sda_low <= 1'b0;
      end else begin
        case (state)
          IDLE: begin
            scl_low <= 1'b0; sda_low <= 1'b0;
            if (launch) begin
              state <= START; ph <= '0; sh <= tgt; addr_ph <= 1'b1;
              rx <= 1'b0; stop_after <= 1'b0;
            end
          end
          START: if (tick) begin
            case (ph)
              2'd0: ph <= 2'd1;
              2'd1: if (scl_i) begin sda_low <= 1'b1; ph <= 2'd2; end
              default: begin scl_low <= 1'b1; state <= XFER; ph <= '0; bitn <= '0; end
            endcase
          end
          XFER: if (tick) begin
            case (ph)
              2'd0: begin
                sda_low <= (bitn == 4'd8) ? (rx && !stop_after) : (!rx && !sh[7]);
                ph <= 2'd1;
              end
              2'd1: begin scl_low <= 1'b0; ph <= 2'd2; end
              2'd2: if (scl_i) begin
                ph <= 2'd3;
                if (bitn == 4'd8) ackbit <= sda_i;
                else begin
                  sh <= {sh[6:0], sda_i};
                  if (!rx && !sda_low && !sda_i) begin
                    state <= IDLE; stat[5] <= 1'b1; scl_low <= 1'b0; sda_low <= 1'b0;
                  end
                end
              end
              default: begin
                scl_low <= 1'b1;
                ph <= '0;
                if (bitn != 4'd8) bitn <= bitn + 4'd1;
                else if (addr_ph) begin
                  addr_ph <= 1'b0; stat[0] <= 1'b1; state <= HOLD;
                  if (tgt[0]) stat[1] <= 1'b1; else stat[3] <= 1'b1;
                  if (ackbit) stat[6] <= 1'b1;
                end else if (rx) begin
                  rxb <= sh; stat[1] <= 1'b1;
                  state <= stop_after ? STOP : HOLD;
                end else begin
                  stat[2] <= 1'b1; stat[3] <= 1'b1; state <= HOLD;
                  if (ackbit) stat[6] <= 1'b1;
                end
              end
            endcase
          end
          HOLD: begin
            if (!tgt[0]) begin
              if (ctrl[1]) begin state <= STOP; ph <= '0; end
              else if (wr_data) begin
                sh <= wdata[7:0]; rx <= 1'b0; state <= XFER; ph <= '0; bitn <= '0;
              end
            end else if (ctrl[1] && stat[6]) begin
              state <= STOP; ph <= '0;
            end else if (!stat[1]) begin
              rx <= 1'b1; stop_after <= ctrl[1]; state <= XFER; ph <= '0; bitn <= '0;
            end
          end
          STOP: if (tick) begin
            case (ph)
              2'd0: begin sda_low <= 1'b1; ph <= 2'd1; end
              2'd1: begin scl_low <= 1'b0; ph <= 2'd2; end
              2'd2: if (scl_i) begin sda_low <= 1'b0; ph <= 2'd3; end
              default: begin stat[4] <= 1'b1; state <= IDLE; end
            endcase
          end
          default: state <= IDLE;
        endcase
      end
    end
  end

  assert_override_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[4] |=> state == IDLE)
    else $error("override left engine running");

  assert_stop_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[4]) |-> $past(state) == STOP)
    else $error("stop flag without stop sequence");

  assert_sda_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XFER && $past(state) == XFER && !scl_low && !$past(scl_low)) |-> $stable(sda_low))
    else $error("SDA moved while SCL high");

  assert_arb_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[5]) |-> (state == IDLE && !scl_low && !sda_low))
    else $error("arbitration loss did not release bus");

  assert_hold_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == HOLD |-> scl_low)
    else $error("SCL released while waiting on host");
endmodule

// File: tb/tb_i2c_host_ctrl.sv
module tb_i2c_host_ctrl;
  localparam int CLK_P = 10;
  localparam logic [5:0] A_CTRL = 6'h04, A_STAT = 6'h0C, A_IEN = 6'h14, A_TGT = 6'h20, A_DATA = 6'h24;
  localparam logic [6:0] TGT_A = 7'h2C;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, scl_pull, sda_pull;
  logic tgt_sda_low, tgt_hold = 0, force_sda = 0, m_rst = 0;
  int checks = 0, fails = 0;

  wire scl_bus = !scl_pull && !tgt_hold;
  wire sda_bus = !sda_pull && !tgt_sda_low && !force_sda;

  i2c_host_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  always #(CLK_P/2) clk = ~clk;
  initial forever begin @(negedge clk); tick = ~tick; end

  // behavioural I2C target
  logic [7:0] rx_q[$];
  logic acks_q[$];
  logic [7:0] tx_mem [0:3];
  logic [7:0] addr_seen, msh, txb;
  logic p_scl, p_sda, act, seen, mrd, mmatch, mack;
  int rc, lastr, mph, tidx, nstart, nstop;

  initial begin
    tx_mem[0] = 8'h5A; tx_mem[1] = 8'hC3; tx_mem[2] = 8'h0F; tx_mem[3] = 8'hF0;
  end

  always @(posedge clk) begin
    if (!rst_n || m_rst) begin
      p_scl = 1; p_sda = 1; act = 0; seen = 0; rc = 0; lastr = 0; mph = 0; tidx = 0;
      nstart = 0; nstop = 0; mack = 0; mrd = 0; mmatch = 0; msh = '0; txb = '0;
      addr_seen = '0; rx_q.delete(); acks_q.delete(); tgt_sda_low <= 1'b0;
    end else begin
      if (p_scl && scl_bus && p_sda && !sda_bus) begin
        act = 1; rc = 0; seen = 0; mph = 0; nstart++;
      end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
        act = 0; nstop++; tgt_sda_low <= 1'b0;
      end else if (act && !p_scl && scl_bus) begin
        if (rc < 8) msh = {msh[6:0], sda_bus};
        else if (mph == 2) begin mack = sda_bus; acks_q.push_back(sda_bus); end
        lastr = rc; rc = (rc == 8) ? 0 : rc + 1; seen = 1;
      end else if (act && seen && p_scl && !scl_bus) begin
        if (lastr == 7) begin
          if (mph == 0) begin
            addr_seen = msh; mrd = msh[0]; mmatch = (msh[7:1] == TGT_A); tgt_sda_low <= mmatch;
          end else if (mph == 1) begin rx_q.push_back(msh); tgt_sda_low <= 1'b1; end
          else tgt_sda_low <= 1'b0;
        end else if (lastr == 8) begin
          tgt_sda_low <= 1'b0;
          if (mph == 0) mph = !mmatch ? 3 : (mrd ? 2 : 1);
          else if (mph == 2 && mack) mph = 3;
          if (mph == 2) begin
            txb = tx_mem[tidx % 4]; tidx++; tgt_sda_low <= !txb[7];
          end
        end else if (mph == 2) tgt_sda_low <= !txb[6-lastr];
      end
      p_scl = scl_bus; p_sda = sda_bus;
    end
  end

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act_v, exp_v);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic poll(input logic [6:0] m, input string req);
    logic [31:0] v;
    bit got = 0;
    for (int i = 0; i < 5000 && !got; i++) begin
      reg_rd(A_STAT, v);
      got = (v[6:0] & m) != 0;
    end
    if (!got) begin
      checks++; fails++;
      $display("FAIL %s actual=timeout expected=flag 0x%0h", req, m);
    end
  endtask

  task automatic model_reset();
    @(negedge clk); m_rst = 1; @(negedge clk); m_rst = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int ns;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    reg_rd(A_CTRL, v); chk("R1 ctrl reset", v, 0);
    reg_rd(A_STAT, v); chk("R1 stat reset", v, 0);
    chk("R1 lines released", {scl_pull, sda_pull, irq}, 0);

    reg_wr(A_CTRL, 32'hC6); reg_rd(A_CTRL, v); chk("R1 ctrl readback", v, 32'hC6);
    reg_wr(A_IEN, 32'h55);  reg_rd(A_IEN, v);  chk("R1 ien readback", v, 32'h55);
    reg_wr(A_TGT, 32'hA4);  reg_rd(A_TGT, v);  chk("R1 addr readback", v, 32'hA4);
    reg_wr(A_CTRL, 0); reg_wr(A_IEN, 0);

    reg_wr(A_CTRL, 32'h30); chk("R11 scl pulled sda released", {scl_pull, sda_pull}, 2'b10);
    reg_wr(A_CTRL, 32'h50); chk("R11 scl released sda pulled", {scl_pull, sda_pull}, 2'b01);
    reg_wr(A_CTRL, 32'h79);
    repeat (100) @(negedge clk);
    reg_rd(A_STAT, v); chk("R11 engine idle under override", v, 0);
    chk("R11 both released", {scl_pull, sda_pull}, 0);
    reg_wr(A_CTRL, 0);
    repeat (4) @(negedge clk);
    model_reset();

    // write transfer
    reg_wr(A_TGT, {24'h0, TGT_A, 1'b0});
    reg_wr(A_CTRL, 32'h89);
    poll(7'h01, "R4 write address done");
    reg_rd(A_STAT, v); chk("R4 write address flags", v, 32'h09);
    chk("R3 start seen", nstart, 1);
    chk("R3 address byte", addr_seen, {TGT_A, 1'b0});

    chk("R12 irq masked", irq, 0);
    reg_wr(A_IEN, 32'h08); chk("R12 irq enabled", irq, 1);
    reg_wr(A_IEN, 32'h04); chk("R12 irq other bit", irq, 0);
    reg_wr(A_IEN, 0);

    reg_wr(A_STAT, 0); reg_rd(A_STAT, v); chk("R2 clear all", v, 0);
    reg_wr(A_DATA, 32'hA5);
    poll(7'h04, "R6 byte sent");
    reg_rd(A_STAT, v); chk("R6 write flags", v, 32'h0C);
    chk("R6 byte count", rx_q.size(), 1);
    if (rx_q.size() > 0) chk("R6 byte value", rx_q[0], 32'hA5);
    reg_wr(A_STAT, 32'h7B); reg_rd(A_STAT, v); chk("R2 clear one bit", v, 32'h08);

    reg_wr(A_STAT, 0);
    reg_wr(A_DATA, 32'h3C);
    repeat (10) @(negedge clk);
    while (scl_bus) @(negedge clk);
    tgt_hold = 1;
    repeat (300) @(negedge clk);
    reg_rd(A_STAT, v); chk("R13 stalled while SCL held", v[2], 0);
    @(negedge clk); tgt_hold = 0;
    poll(7'h04, "R13 byte after release");
    chk("R13 byte count", rx_q.size(), 2);
    if (rx_q.size() > 1) chk("R13 byte value", rx_q[1], 32'h3C);

    ns = nstop;
    reg_wr(A_CTRL, 32'h8A);
    poll(7'h10, "R9 write stop");
    repeat (4) @(negedge clk);
    chk("R9 stop seen", nstop, ns + 1);
    chk("R9 lines released", {scl_pull, sda_pull}, 0);
    reg_wr(A_CTRL, 0); reg_wr(A_STAT, 0);

    // read transfer
    reg_wr(A_TGT, {24'h0, TGT_A, 1'b1});
    reg_wr(A_CTRL, 32'h89);
    poll(7'h01, "R4 read address done");
    reg_rd(A_STAT, v); chk("R4 read address flags", v, 32'h03);
    reg_wr(A_CTRL, 32'h88);
    reg_wr(A_STAT, 32'h7D);
    poll(7'h02, "R7 byte received");
    reg_rd(A_DATA, v); chk("R7 read data", v, 32'h5A);
    chk("R7 ack count", acks_q.size(), 1);
    if (acks_q.size() > 0) chk("R7 master acked", acks_q[0], 0);

    ns = nstop;
    reg_wr(A_CTRL, 32'h8A);
    reg_wr(A_STAT, 32'h7D);
    poll(7'h10, "R8 read stop");
    reg_rd(A_DATA, v); chk("R8 last read data", v, 32'hC3);
    reg_rd(A_STAT, v); chk("R8 flags", v & 32'h12, 32'h12);
    chk("R8 ack count", acks_q.size(), 2);
    if (acks_q.size() > 1) chk("R8 master nacked", acks_q[1], 1);
    repeat (4) @(negedge clk);
    chk("R8 stop seen", nstop, ns + 1);
    reg_wr(A_CTRL, 0); reg_wr(A_STAT, 0);

    // address not acknowledged
    reg_wr(A_TGT, {24'h0, 7'h11, 1'b0});
    reg_wr(A_CTRL, 32'h89);
    poll(7'h01, "R5 address done");
    reg_rd(A_STAT, v); chk("R5 nack flag", v, 32'h49);
    reg_wr(A_CTRL, 32'h8A);
    poll(7'h10, "R9 stop after nack");
    reg_wr(A_CTRL, 0); reg_wr(A_STAT, 0);

    // arbitration loss
    reg_wr(A_TGT, {24'h0, TGT_A, 1'b0});
    @(negedge clk); force_sda = 1;
    reg_wr(A_CTRL, 32'h89);
    poll(7'h20, "R10 arbitration");
    reg_rd(A_STAT, v); chk("R10 flags", v, 32'h20);
    chk("R10 lines released", {scl_pull, sda_pull}, 0);
    @(negedge clk); force_sda = 0;
    model_reset();

    finish_run();
  end
endmodule